// File: doc/BRIEF.md
# Incremental Position Counter with Selectable Count Source

The block keeps a signed position count for an interpolating encoder front end. Each cycle it can receive a zero-crossing strobe, an interpolation-step strobe, a direction level and an index pulse. A five-bit control word sets which strobe advances the count and where the count enable comes from. The enable is either a register bit or the level on a shared multi-function pin. The control word also sets whether the index pulse clears the count, and it holds a software clear.

The control word also sets the direction of the shared pin. When the enable comes from the register, the pin is free to serve as an output and the pin output-enable is asserted. When the enable comes from the pin, the output-enable is dropped and the pin level gates counting. The count is two's complement and wraps at both ends.

Top module: `enc_pos_counter`

## Requirements
- R1: Control bit 0 selects the count source: at 0 only `zero_stb_i` is a count event, at 1 only `step_stb_i` is; the other strobe has no effect on `count_o`.
- R2: Control bit 1 selects the enable source: at 0 `mfp_oe_o` is 1 and control bit 2 gates counting; at 1 `mfp_oe_o` is 0 and the level on `mfp_i` gates counting.
- R3: With control bit 1 at 0, control bit 2 at 0 holds `count_o`, and control bit 2 at 1 lets count events change it.
- R4: With control bit 3 at 1, `index_i` high clears `count_o` to zero on the next edge; with control bit 3 at 0, `index_i` has no effect.
- R5: While control bit 4 is 1, `count_o` is forced to zero regardless of every other input.
- R6: An enabled count event adds one to `count_o` when `dir_i` is 1 and subtracts one when `dir_i` is 0, with `dir_i` sampled in the same cycle as the strobe.
- R7: `count_o` is CNT_W-bit two's complement and wraps from all-ones to zero going up and from zero to all-ones going down.
- R8: Priority is software clear, then index clear, then the count event: an index clear and an enabled event in the same cycle leave `count_o` at zero.
- R9: After reset the control word is all zeros, `count_o` is zero and `mfp_oe_o` is 1.
- R10: A control write on `ctrl_we_i` takes effect from the next cycle; inputs in the write cycle are judged by the previous control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 5 | Control word: bit0 source, bit1 enable source, bit2 enable, bit3 index clear, bit4 software clear |
| zero_stb_i | input | 1 | Zero-crossing strobe, one cycle |
| step_stb_i | input | 1 | Interpolation-step strobe, one cycle |
| dir_i | input | 1 | Direction of motion, 1 = up |
| index_i | input | 1 | Index pulse |
| mfp_i | input | 1 | Multi-function pin level, the enable in pin mode |
| mfp_oe_o | output | 1 | Multi-function pin output enable |
| count_o | output | CNT_W | Position count, two's complement |

## Verification
The bench goes through all 32 control words and, for each, all 32 combinations of the two strobes, direction, index and pin level. This exposes a design that follows the wrong strobe, ignores the pin level in pin mode, or honours the register enable in pin mode. The same sweep also catches a design that lets the index pulse clear the count when index clear is off. A same-cycle index and event catches a reversed priority, which would leave plus or minus one instead of zero. A long run down from zero and back up catches a saturating or mis-sized counter at the wrap. A write that arrives together with an event catches a control word that is applied combinationally rather than from the next cycle.

// File: rtl/enc_pos_pkg.sv
package enc_pos_pkg;
  localparam int unsigned CTRL_W = 5;

  // bit order is the software-visible layout of the control word
  typedef struct packed {
    logic sw_clr;    // bit4
    logic idx_clr;   // bit3
    logic sw_en;     // bit2
    logic pin_en;    // bit1
    logic src_step;  // bit0
  } ctrl_t;
endpackage

// File: rtl/enc_ctrl_reg.sv
module enc_ctrl_reg
  import enc_pos_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              mfp_i,
  output ctrl_t             ctrl_o,
  output logic              mfp_oe_o,
  output logic              cnt_en_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assign ctrl_o   = ctrl_q;
  assign mfp_oe_o = ~ctrl_q.pin_en;
  assign cnt_en_o = ctrl_q.pin_en ? mfp_i : ctrl_q.sw_en;
endmodule

// File: rtl/enc_evt_sel.sv
module enc_evt_sel (
  input  logic src_step_i,
  input  logic cnt_en_i,
  input  logic zero_stb_i,
  input  logic step_stb_i,
  input  logic dir_i,
  output logic up_o,
  output logic dn_o
);
  logic evt;

  assign evt  = (src_step_i ? step_stb_i : zero_stb_i) & cnt_en_i;
  assign up_o = evt & dir_i;
  assign dn_o = evt & ~dir_i;
endmodule

// File: rtl/enc_pos_core.sv
module enc_pos_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_clr_i,
  input  logic             idx_clr_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sw_clr_i)       cnt_d = '0;
    else if (idx_clr_i) cnt_d = '0;
    else if (up_i)      cnt_d = cnt_q + ONE;
    else if (dn_i)      cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
  import enc_pos_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              zero_stb_i,
  input  logic              step_stb_i,
  input  logic              dir_i,
  input  logic              index_i,
  input  logic              mfp_i,
  output logic              mfp_oe_o,
  output logic [CNT_W-1:0]  count_o
);
  ctrl_t ctrl_q;
  logic  cnt_en, up, dn;

  enc_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .mfp_i    (mfp_i),
    .ctrl_o   (ctrl_q),
    .mfp_oe_o (mfp_oe_o),
    .cnt_en_o (cnt_en)
  );

  enc_evt_sel u_evt (
    .src_step_i (ctrl_q.src_step),
    .cnt_en_i   (cnt_en),
    .zero_stb_i (zero_stb_i),
    .step_stb_i (step_stb_i),
    .dir_i      (dir_i),
    .up_o       (up),
    .dn_o       (dn)
  );

  enc_pos_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_clr_i  (ctrl_q.sw_clr),
    .idx_clr_i (ctrl_q.idx_clr & index_i),
    .up_i      (up),
    .dn_i      (dn),
    .count_o   (count_o)
  );
endmodule

// File: rtl/enc_pos_counter_chk.sv
module enc_pos_counter_chk
  import enc_pos_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input ctrl_t            ctrl_q,
  input logic             zero_stb_i,
  input logic             step_stb_i,
  input logic             index_i,
  input logic             mfp_i,
  input logic [CNT_W-1:0] count_o
);
  logic clr_any;
  assign clr_any = ctrl_q.sw_clr | (ctrl_q.idx_clr & index_i);

  p_sw_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.sw_clr |=> count_o == '0);

  p_index_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.idx_clr && index_i) |=> count_o == '0);

  p_reg_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.pin_en && !ctrl_q.sw_en && !clr_any) |=> $stable(count_o));

  p_pin_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pin_en && !mfp_i && !clr_any) |=> $stable(count_o));

  p_unselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_any && (ctrl_q.src_step ? !step_stb_i : !zero_stb_i)) |=> $stable(count_o));

  p_unit_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_any |=> (count_o == $past(count_o) ||
                  count_o == $past(count_o) + CNT_W'(1) ||
                  count_o == $past(count_o) - CNT_W'(1)));
endmodule

bind enc_pos_counter enc_pos_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_q     (ctrl_q),
  .zero_stb_i (zero_stb_i),
  .step_stb_i (step_stb_i),
  .index_i    (index_i),
  .mfp_i      (mfp_i),
  .count_o    (count_o)
);

// File: tb/enc_pos_counter_bench.sv
module enc_pos_counter_bench;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   wd = '0;
  logic         zs = 1'b0, ss = 1'b0, dir = 1'b0, idx = 1'b0, mfp = 1'b0;
  logic         mfp_oe;
  logic [W-1:0] cnt;

  int total = 0;
  int bad = 0;

  logic [4:0]   m_ctrl;
  logic [W-1:0] m_cnt;

  always #5 clk = ~clk;

  enc_pos_counter #(.CNT_W(W)) u_enc_pos_counter (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .zero_stb_i(zs), .step_stb_i(ss), .dir_i(dir), .index_i(idx),
    .mfp_i(mfp), .mfp_oe_o(mfp_oe), .count_o(cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, sample 1 ns after it
  task automatic cyc(input string tag, input logic w, input logic [4:0] d,
                     input logic z, input logic s, input logic dr,
                     input logic ix, input logic m);
    logic evt, en;
    string t;
    @(negedge clk);
    we = w; wd = d; zs = z; ss = s; dir = dr; idx = ix; mfp = m;
    @(posedge clk);
    en  = m_ctrl[1] ? m : m_ctrl[2];
    evt = (m_ctrl[0] ? s : z) && en;
    if (m_ctrl[4])               begin m_cnt = '0; t = "R5"; end
    else if (m_ctrl[3] && ix)    begin m_cnt = '0; t = "R4"; end
    else if (evt)                begin m_cnt = dr ? m_cnt + 1'b1 : m_cnt - 1'b1; t = "R6"; end
    else                         t = "R3";
    if (w) m_ctrl = d;
    #1;
    chk(tag == "" ? t : tag, int'(cnt), int'(m_cnt));
    chk("R2", int'(mfp_oe), int'(!m_ctrl[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_ctrl = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk("R9", int'(cnt), 0);
    chk("R9", int'(mfp_oe), 1);

    // R10: enable write together with event, event judged by old word
    cyc("R10", 1, 5'b00100, 1, 0, 1, 0, 0);
    cyc("R1",  0, 5'b00000, 1, 0, 1, 0, 0);
    cyc("R1",  0, 5'b00000, 0, 1, 1, 0, 0);
    cyc("",    1, 5'b00101, 0, 0, 0, 0, 0);
    cyc("R1",  0, 5'b00000, 1, 0, 1, 0, 0);
    cyc("R1",  0, 5'b00000, 0, 1, 1, 0, 0);

    // R8: index clear and enabled event in one cycle
    cyc("",   1, 5'b01100, 0, 0, 0, 0, 0);
    cyc("",   0, 5'b00000, 1, 0, 1, 0, 0);
    cyc("R8", 0, 5'b00000, 1, 0, 1, 1, 0);
    cyc("",   1, 5'b11100, 0, 0, 0, 0, 0);
    cyc("R8", 0, 5'b00000, 1, 0, 1, 1, 0);

    // R7: wrap down through zero, then up through all-ones
    cyc("", 1, 5'b00100, 0, 0, 0, 0, 0);
    cyc("R7", 0, 5'b00000, 1, 0, 0, 0, 0);
    chk("R7", int'(cnt), (1 << W) - 1);
    for (int i = 0; i < (1 << W) + 3; i++) cyc("R7", 0, 5'b00000, 1, 0, 1, 0, 0);
    chk("R7", int'(cnt), 2);

    // sweep every control word against every input combination
    for (int c = 0; c < 32; c++) begin
      cyc("", 1, 5'(c), 0, 0, 0, 0, 0);
      for (int s = 0; s < 32; s++)
        cyc("", 0, 5'b00000, s[0], s[1], s[2], s[3], s[4]);
      // keep the count away from zero between words
      cyc("", 1, 5'b00100, 0, 0, 0, 0, 0);
      for (int k = 0; k < 3; k++) cyc("", 0, 5'b00000, 1, 0, 1, 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule